// File: doc/BRIEF.md
# Timer Channel with Mode-Dependent Event Flag

This block is one 16-bit timer channel together with the main counter it watches. The counter runs without stopping. It either counts up and wraps at a modulo value, or it counts up and then back down, for symmetric waveforms. The channel has four modes:

- **Input capture:** the channel records the count on a chosen edge of a pin.
- **Output compare:** the channel toggles its pin when the count equals the channel value.
- **Edge-aligned PWM:** the channel drives a pulse that starts at the counter wrap.
- **Center-aligned PWM:** the channel drives a pulse that is centred on the count of zero.

The channel has a single event flag, and its meaning follows the mode. In capture mode it means an edge was captured. In compare and edge-aligned PWM modes it means the count matched the channel value. In center-aligned PWM it is set at both duty-cycle edges.

Software clears the flag with two accesses. First it reads the status while the flag is set. Then it writes a zero to the flag bit. If a new event lands between those two accesses, the flag stays set, so the event is not lost. The interrupt request is the flag gated by an enable.

Top module: `tmr_chan`

## Requirements
- R1: When `mode` is not 3, `cnt` steps up by one per clock. When `cnt` is at or above `mod_val`, the next value is 0. `cnt_down` is 0 in these modes.
- R2: When `mode` is 3, `cnt` counts up to `mod_val`, then down to 0, then up again. `cnt_down` is 0 while the count rises, including the cycle at `mod_val`. It is 1 while the count falls, including the cycle at 0.
- R3: In capture mode (`mode` 0), `edge_sel` selects the edge: 0 ignores the pin, 1 means rising edges, 2 means falling edges and 3 means both. A selected edge sets `flag`. An edge that is not selected leaves `flag` and `val_rdata` unchanged.
- R4: On a selected edge, `val_rdata` takes the count that appears two clocks after the cycle in which `pin_in` changed. This lag comes from a two-flop synchronizer.
- R5: In output compare mode (`mode` 1), the clock edge that ends a cycle with `cnt == val_rdata` sets `flag` and toggles `pin_out`.
- R6: In edge-aligned PWM (`mode` 2), `pin_out` is 1 exactly while `cnt < val_rdata`. The match cycle sets `flag`.
- R7: In center-aligned PWM (`mode` 3), `pin_out` is 1 exactly while `cnt < val_rdata`. The match on the rising slope sets `flag`, and so does the match on the falling slope.
- R8: `flag` clears only after two accesses. The first is an `sts_rd` pulse while `flag` is 1. The second is a later `sts_we` with `sts_wdata` 0. A write made without that read, or a write of 1, leaves `flag` set.
- R9: A flag-setting event between the read and the write cancels the clear: the write then leaves `flag` at 1.
- R10: `irq` is 1 exactly when `flag` and `irq_en` are both 1.
- R11: After reset, `cnt`, `cnt_down`, `val_rdata`, `flag`, `irq` and `pin_out` are all 0.
- R12: A `val_we` pulse loads `val_wdata` into the channel value. The new value is seen on `val_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_val | input | W | Counter modulo value |
| mode | input | 2 | Mode: 0 capture, 1 compare, 2 edge PWM, 3 center PWM |
| edge_sel | input | 2 | Capture edge: 0 off, 1 rising, 2 falling, 3 both |
| irq_en | input | 1 | Interrupt enable |
| pin_in | input | 1 | Asynchronous capture pin |
| val_we | input | 1 | Channel value write strobe |
| val_wdata | input | W | Channel value write data |
| sts_rd | input | 1 | Status read strobe |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Value written to the flag bit |
| cnt | output | W | Main counter value |
| cnt_down | output | 1 | Counter is on its falling slope |
| val_rdata | output | W | Channel value register |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Compare or PWM pin |

## Verification
The hardest case to reach is an event landing exactly between the status read and the clearing write. The stimulus waits, in compare mode, until the count is one below the channel value. It issues the read on that cycle and the write on the match cycle, so the event and the write meet at the same clock edge.

The center-aligned sweep uses the same counter-driven timing. It places each clear between the rising and falling matches, so each of the two flag sets is seen separately.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mod_val,
  input  logic [1:0]   mode,
  input  logic [1:0]   edge_sel,
  input  logic         irq_en,
  input  logic         pin_in,
  input  logic         val_we,
  input  logic [W-1:0] val_wdata,
  input  logic         sts_rd,
  input  logic         sts_we,
  input  logic         sts_wdata,
  output logic [W-1:0] cnt,
  output logic         cnt_down,
  output logic [W-1:0] val_rdata,
  output logic         flag,
  output logic         irq,
  output logic         pin_out
);
  localparam logic [1:0] M_CAP = 2'd0, M_OC = 2'd1, M_CPWM = 2'd3;

  logic [W-1:0] cnt_q, chv_q;
  logic dn_q, s1_q, s2_q, s3_q, flag_q, armed_q, oc_q;

  wire center = (mode == M_CPWM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (center) begin
      if (mod_val == '0) begin
        cnt_q <= '0;
        dn_q  <= 1'b0;
      end else if (!dn_q) begin
        if (cnt_q >= mod_val) begin
          dn_q  <= 1'b1;
          cnt_q <= mod_val - 1'b1;
        end else
          cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q == '0) begin
        dn_q  <= 1'b0;
        cnt_q <= W'(1);
      end else
        cnt_q <= cnt_q - 1'b1;
    end else begin
      dn_q  <= 1'b0;
      cnt_q <= (cnt_q >= mod_val) ? '0 : cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1_q, s2_q, s3_q} <= 3'b000;
    else        {s1_q, s2_q, s3_q} <= {pin_in, s1_q, s2_q};

  wire rise    = s2_q & ~s3_q;
  wire fall    = ~s2_q & s3_q;
  wire cap_evt = (mode == M_CAP) & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  wire match   = (cnt_q == chv_q);
  wire cmp_evt = (mode != M_CAP) & match;
  wire evt     = cap_evt | cmp_evt;
  wire clr     = sts_we & ~sts_wdata & armed_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       chv_q <= '0;
    else if (cap_evt) chv_q <= cnt_q;
    else if (val_we)  chv_q <= val_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= evt | (flag_q & ~clr);
      if (evt | sts_we)        armed_q <= 1'b0;
      else if (sts_rd & flag_q) armed_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           oc_q <= 1'b0;
    else if ((mode == M_OC) & match)      oc_q <= ~oc_q;

  assign cnt       = cnt_q;
  assign cnt_down  = dn_q;
  assign val_rdata = chv_q;
  assign flag      = flag_q;
  assign irq       = flag_q & irq_en;
  assign pin_out   = (mode == M_OC) ? oc_q : (mode[1] & (cnt_q < chv_q));
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mod_val,
  input logic [1:0]   mode,
  input logic [1:0]   edge_sel,
  input logic         val_we,
  input logic         sts_we,
  input logic         sts_wdata,
  input logic [W-1:0] cnt,
  input logic         cnt_down,
  input logic [W-1:0] val_rdata,
  input logic         flag,
  input logic         irq,
  input logic         armed
);
  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3 && $stable(mod_val) && cnt <= mod_val) |=> cnt <= mod_val);

  // R2
  cpwm_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && mod_val != '0 && cnt == mod_val && !cnt_down) |=> cnt_down);

  // R3
  cap_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && edge_sel == 2'd0 && !val_we) |=> $stable(val_rdata));

  // R5
  oc_match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && cnt == val_rdata) |=> flag);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(sts_we && !sts_wdata && armed));

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_val(mod_val), .mode(mode), .edge_sel(edge_sel),
  .val_we(val_we), .sts_we(sts_we), .sts_wdata(sts_wdata), .cnt(cnt),
  .cnt_down(cnt_down), .val_rdata(val_rdata), .flag(flag), .irq(irq),
  .armed(armed_q)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
  localparam int W = 16;
  localparam int M = 7;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] mod_val = W'(M);
  logic [1:0] mode = 2'd0, edge_sel = 2'd0;
  logic irq_en = 0, pin_in = 0, val_we = 0, sts_rd = 0, sts_we = 0, sts_wdata = 0;
  logic [W-1:0] val_wdata = '0;
  logic [W-1:0] cnt, val_rdata;
  logic cnt_down, flag, irq, pin_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_chan #(.W(W)) u0 (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cnt(input int v, input int dn);
    for (int i = 0; i < 100; i++) begin
      if (int'(cnt) == v && (dn < 0 || int'(cnt_down) == dn)) return;
      tick;
    end
    chk(0, "wait_cnt timeout", int'(cnt), v);
  endtask

  task automatic do_clear;
    sts_rd = 1; tick;
    sts_rd = 0; sts_we = 1; sts_wdata = 0; tick;
    sts_we = 0;
  endtask

  task automatic load_val(input int v);
    val_we = 1; val_wdata = W'(v); tick;
    val_we = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual %0d expected %0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, ov, p;
    bit exp;
    repeat (3) tick;
    // R11 reset state
    chk(cnt == 0 && cnt_down == 0 && val_rdata == 0 && flag == 0 && irq == 0 && pin_out == 0,
        "R11 reset", int'(cnt) + int'(flag) + int'(val_rdata), 0);
    rst_n = 1;
    // R1 up count with wrap
    for (int i = 0; i < 20; i++) begin
      chk(int'(cnt) == i % (M + 1) && cnt_down == 0, "R1 count", int'(cnt), i % (M + 1));
      tick;
    end
    // R12 value write
    load_val(16'h1234);
    chk(val_rdata == 16'h1234, "R12 write", int'(val_rdata), 16'h1234);

    // R3 R4 capture edge select sweep
    for (int es = 0; es < 4; es++) begin
      edge_sel = 2'(es);
      for (int pol = 0; pol < 2; pol++) begin
        do_clear;
        repeat (2) tick;
        ov = int'(val_rdata);
        c0 = int'(cnt);
        pin_in = (pol == 0);
        repeat (4) tick;
        exp = (es == 3) || (es == 1 && pol == 0) || (es == 2 && pol == 1);
        chk(flag == exp, $sformatf("R3 flag es=%0d pol=%0d", es, pol), int'(flag), int'(exp));
        if (exp)
          chk(int'(val_rdata) == (c0 + 2) % (M + 1), "R4 captured count", int'(val_rdata), (c0 + 2) % (M + 1));
        else
          chk(int'(val_rdata) == ov, "R3 value held", int'(val_rdata), ov);
      end
    end
    edge_sel = 2'd0;

    // R5 output compare sweep
    mode = 2'd1;
    for (int v = 0; v <= M; v++) begin
      load_val(v);
      wait_cnt((v + 1) % (M + 1), -1);
      do_clear;
      wait_cnt(v, -1);
      chk(flag == 0, "R5 flag before match", int'(flag), 0);
      p = int'(pin_out);
      tick;
      chk(flag == 1, "R5 flag after match", int'(flag), 1);
      chk(int'(pin_out) == 1 - p, "R5 pin toggle", int'(pin_out), 1 - p);
    end

    // R8 clear handshake cases (flag set, count just past value)
    load_val(3);
    wait_cnt(4, -1);
    chk(flag == 1, "R8 setup", int'(flag), 1);
    sts_we = 1; sts_wdata = 0; tick; sts_we = 0;
    chk(flag == 1, "R8 write without read", int'(flag), 1);
    sts_rd = 1; tick; sts_rd = 0; sts_we = 1; sts_wdata = 1; tick; sts_we = 0;
    chk(flag == 1, "R8 write of one", int'(flag), 1);
    sts_rd = 1; tick; sts_rd = 0; sts_we = 1; sts_wdata = 0; tick; sts_we = 0;
    chk(flag == 0, "R8 full handshake", int'(flag), 0);

    // R9 event between read and write
    wait_cnt(4, -1);
    wait_cnt(2, -1);
    sts_rd = 1; tick;
    sts_rd = 0; sts_we = 1; sts_wdata = 0; tick;
    sts_we = 0;
    chk(flag == 1, "R9 event kept", int'(flag), 1);
    // R10 interrupt gating
    irq_en = 0; tick;
    chk(irq == 0, "R10 irq masked", int'(irq), 0);
    irq_en = 1; tick;
    chk(irq == 1, "R10 irq raised", int'(irq), 1);
    do_clear;
    chk(flag == 0 && irq == 0, "R10 irq dropped", int'(irq), 0);
    irq_en = 0;

    // R6 edge-aligned PWM
    mode = 2'd2;
    for (int v = 0; v <= M + 1; v++) begin
      load_val(v);
      for (int i = 0; i < M + 1; i++) begin
        chk(pin_out == (int'(cnt) < v), "R6 pin", int'(pin_out), int'(int'(cnt) < v));
        tick;
      end
      if (v <= M) begin
        wait_cnt((v + 1) % (M + 1), -1);
        do_clear;
        wait_cnt(v, -1);
        chk(flag == 0, "R6 flag before match", int'(flag), 0);
        tick;
        chk(flag == 1, "R6 flag at match", int'(flag), 1);
      end
    end

    // R2 up/down count
    mode = 2'd3;
    wait_cnt(1, 0);
    for (int i = 1; i < 30; i++) begin
      int k, e, d;
      k = i % (2 * M);
      e = (k <= M) ? k : 2 * M - k;
      d = (k > M || k == 0) ? 1 : 0;
      chk(int'(cnt) == e && int'(cnt_down) == d, "R2 count", int'(cnt), e);
      tick;
    end

    // R7 center-aligned PWM pin and both matches
    for (int v = 0; v <= M + 1; v++) begin
      load_val(v);
      for (int i = 0; i < 2 * M; i++) begin
        chk(pin_out == (int'(cnt) < v), "R7 pin", int'(pin_out), int'(int'(cnt) < v));
        tick;
      end
    end
    for (int v = 2; v <= 5; v++) begin
      load_val(v);
      wait_cnt(v, 1);
      tick;
      do_clear;
      wait_cnt(v, 0);
      chk(flag == 0, "R7 before rising match", int'(flag), 0);
      tick;
      chk(flag == 1, "R7 rising match", int'(flag), 1);
      do_clear;
      wait_cnt(v, 1);
      chk(flag == 0, "R7 before falling match", int'(flag), 0);
      tick;
      chk(flag == 1, "R7 falling match", int'(flag), 1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule